// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Software Break Override

This block serialises bytes onto a single transmit line and lets software take direct control of that line. A byte written into a one-deep holding register moves into a frame shifter as soon as the shifter is free. The shifter sends a low start bit, the data bits least significant first, an optional parity bit and a high stop bit. Each bit lasts a fixed number of baud ticks. The baud ticks come from an external divider as one-cycle strobes on `baud_tick`.

A transmit-enable input decides who owns the line. When it is 1, the shifter drives the line and the output enable is always on. When it is 0, the shifter and the holding register are held cleared, and the line level and output enable follow two port bits kept by software. Software gets a clean mark level before enabling by setting both port bits to 1. It sends a break by setting the port data bit to 0 and then dropping transmit-enable. This cuts off any frame in progress and leaves the line low for as long as software wants.

Top module: `uart_tx_brk`

## Requirements
- R1: While `rst_n` is low, after a clock edge `txd` is 1, `txd_oe` is 0 and `tdr_empty` is 1.
- R2: While `tx_en` is 0, on every clock edge `txd` takes the value of `port_dat` and `txd_oe` takes the value of `port_oe`, so the pin follows the port bits one clock later.
- R3: A frame is a start bit of 0, then `wr_data[0]` through `wr_data[7]`, then a parity bit when `par_en` is 1, then a stop bit of 1. The parity bit is the XOR of the eight data bits when `par_odd` is 0, and its inverse when `par_odd` is 1. `par_en` and `par_odd` are taken at the moment the byte enters the shifter.
- R4: Each frame bit lasts exactly 16 clock edges on which `baud_tick` is 1. Clock edges with `baud_tick` at 0 do not advance the frame, and `txd` stays stable across them.
- R5: While `tx_en` is 1 and no frame is being sent, `txd` is 1 and `txd_oe` is 1.
- R6: A write (`wr_valid` 1 at a clock edge) is accepted only when `tx_en` is 1 and `tdr_empty` is 1, and then `tdr_empty` reads 0 after that edge. A write while `tdr_empty` is 0 or while `tx_en` is 0 is ignored and never appears on the line.
- R7: With the shifter idle, the accepted byte moves into the shifter on the next clock edge, which sets `tdr_empty` to 1. The start bit appears on `txd` one clock edge after that.
- R8: A byte waiting in the holding register when a frame ends starts its frame immediately, so its start bit directly follows the previous stop bit with no extra idle time.
- R9: One clock edge after `tx_en` goes to 0, even in the middle of a frame, `txd` equals `port_dat`, `txd_oe` equals `port_oe` and `tdr_empty` is 1. The cut-off byte and any waiting byte are discarded and are not sent when `tx_en` returns to 1.
- R10: One clock edge after `tx_en` goes from 0 to 1, `txd` is 1 and `txd_oe` is 1, whatever the port bits hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle strobe, 16 per bit period |
| tx_en | input | 1 | Transmit enable; 0 hands the pin to the port bits and clears the transmitter |
| port_oe | input | 1 | Software port bit: pin output enable while disabled |
| port_dat | input | 1 | Software port bit: pin level while disabled |
| par_en | input | 1 | Append a parity bit to each frame |
| par_odd | input | 1 | Select odd parity (1) or even parity (0) |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| tdr_empty | output | 1 | Holding register is free to accept a byte |
| txd | output | 1 | Serial line level |
| txd_oe | output | 1 | Serial line output enable |

## Verification
Most wrong internal states show on `txd` within one bit period: a tick counter that is off, a shift register that is misaligned or a bit count that is wrong moves a bit edge or changes a bit value inside the frame. A stale busy or full flag only shows after a frame. It appears as a missing or extra frame, or a gap or overlap between frames, which is why the line is watched through back-to-back traffic and through long idle stretches after an abort. Ownership errors in the pin register show on the very next clock after `tx_en` changes, so those edges are sampled one cycle later.

// File: rtl/uart_tx_pkg.sv
// Shared types and helpers for the serial transmitter.
// Assumes: configuration bits are stable while a byte enters the shifter.
package uart_tx_pkg;

    // Per-frame format selection, captured when a byte is loaded.
    typedef struct packed {
        logic par_en;
        logic par_odd;
    } tx_cfg_t;

    // Parity bit from the reduced XOR of the data and the odd/even choice.
    function automatic logic parity_of(input logic data_xor, input logic odd);
        return data_xor ^ odd;
    endfunction

endpackage

// File: rtl/uart_tx_holdreg.sv
// One-deep holding register in front of the shifter.
// Accepts a byte only when empty; the shifter takes it with 'take'.
// Assumes: 'clr' is asserted whenever transmission is disabled.
module uart_tx_holdreg #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    // Capture a byte when free; drop it on take or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            full <= 1'b0;
            data <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_valid && !full) begin
            full <= 1'b1;
            data <= wr_data;
        end
    end

endmodule

// File: rtl/uart_tx_shifter.sv
// Frame engine: builds start/data/parity/stop into a shift register
// and moves one bit on after OVERSAMPLE baud ticks.
// Loads the next byte in the same cycle the previous frame ends.
// Assumes: OVERSAMPLE >= 2; 'clr' aborts any frame at once.
module uart_tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              baud_tick,
    input  tx_cfg_t           cfg,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    output logic              take,
    output logic              line
);

    localparam int unsigned FRAME_W = DATA_W + 3;
    localparam int unsigned TICK_W  = $clog2(OVERSAMPLE);
    localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

    logic               busy;
    logic [FRAME_W-1:0] sh;
    logic [TICK_W-1:0]  tick_cnt;
    logic [CNT_W-1:0]   bits_left;
    logic               tick_last;
    logic               frame_done;
    logic [FRAME_W-1:0] next_frame;
    logic [CNT_W-1:0]   next_len;
    logic               par;

    // End-of-bit and end-of-frame detection.
    always_comb begin
        tick_last  = (tick_cnt == TICK_W'(OVERSAMPLE - 1));
        frame_done = busy && baud_tick && tick_last && (bits_left == CNT_W'(1));
        take       = hold_full && !clr && (!busy || frame_done);
    end

    // Assemble the next frame from the held byte and configuration.
    always_comb begin
        par = parity_of(^hold_data, cfg.par_odd);
        if (cfg.par_en) begin
            next_frame = {1'b1, par, hold_data, 1'b0};
            next_len   = CNT_W'(FRAME_W);
        end else begin
            next_frame = {2'b11, hold_data, 1'b0};
            next_len   = CNT_W'(FRAME_W - 1);
        end
    end

    // Load, tick counting and bit shifting.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            busy      <= 1'b0;
            sh        <= '1;
            tick_cnt  <= '0;
            bits_left <= '0;
        end else if (take) begin
            busy      <= 1'b1;
            sh        <= next_frame;
            tick_cnt  <= '0;
            bits_left <= next_len;
        end else if (busy && baud_tick) begin
            if (tick_last) begin
                tick_cnt  <= '0;
                sh        <= {1'b1, sh[FRAME_W-1:1]};
                bits_left <= bits_left - CNT_W'(1);
                if (bits_left == CNT_W'(1)) begin
                    busy <= 1'b0;
                end
            end else begin
                tick_cnt <= tick_cnt + TICK_W'(1);
            end
        end
    end

    // Idle mark when no frame is active.
    assign line = busy ? sh[0] : 1'b1;

endmodule

// File: rtl/uart_tx_pinmux.sv
// Output register choosing between the shifter line and software port bits.
// Registering both sources keeps the switch-over to one clean clock edge.
module uart_tx_pinmux (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic line,
    input  logic port_oe,
    input  logic port_dat,
    output logic txd,
    output logic txd_oe
);

    // Select the pin owner and register level and enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txd    <= 1'b1;
            txd_oe <= 1'b0;
        end else if (tx_en) begin
            txd    <= line;
            txd_oe <= 1'b1;
        end else begin
            txd    <= port_dat;
            txd_oe <= port_oe;
        end
    end

endmodule

// File: rtl/uart_tx_brk.sv
// Serial transmitter top: holding register, frame shifter and pin owner mux.
// Dropping tx_en clears the transmitter and returns the pin to software.
// Assumes: baud_tick is a one-cycle strobe from an external divider.
module uart_tx_brk
    import uart_tx_pkg::*;
#(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              tx_en,
    input  logic              port_oe,
    input  logic              port_dat,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tdr_empty,
    output logic              txd,
    output logic              txd_oe
);

    logic              clr;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              line;
    tx_cfg_t           cfg;

    assign clr       = !tx_en;
    assign cfg       = '{par_en: par_en, par_odd: par_odd};
    assign tdr_empty = !hold_full;

    uart_tx_holdreg #(.DATA_W(DATA_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .take     (take),
        .full     (hold_full),
        .data     (hold_data)
    );

    uart_tx_shifter #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .baud_tick (baud_tick),
        .cfg       (cfg),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .take      (take),
        .line      (line)
    );

    uart_tx_pinmux u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .line     (line),
        .port_oe  (port_oe),
        .port_dat (port_dat),
        .txd      (txd),
        .txd_oe   (txd_oe)
    );

endmodule

// File: rtl/uart_tx_brk_chk.sv
// Port-level property checker for uart_tx_brk, attached by bind.
module uart_tx_brk_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic port_oe,
    input logic port_dat,
    input logic wr_valid,
    input logic tdr_empty,
    input logic txd,
    input logic txd_oe
);

    // Disabled: pin follows port bits one clock later.
    p_port_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (txd == $past(port_dat)) && (txd_oe == $past(port_oe)));

    // Disabled: holding register reads empty.
    p_empty_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> tdr_empty);

    // Enabling: clean mark on the next clock.
    p_mark_on_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !$past(tx_en)) |=> (txd && txd_oe));

    // Enabled: transmitter always drives the pin.
    p_drive_when_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |=> txd_oe);

    // Accepted write fills the holding register.
    p_accept_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && tdr_empty && wr_valid) |=> !tdr_empty);

endmodule

bind uart_tx_brk uart_tx_brk_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .port_oe   (port_oe),
    .port_dat  (port_dat),
    .wr_valid  (wr_valid),
    .tdr_empty (tdr_empty),
    .txd       (txd),
    .txd_oe    (txd_oe)
);

// File: tb/uart_tx_brk_bench.sv
module uart_tx_brk_bench;

    localparam int CLK_PERIOD = 10;
    localparam int OVS        = 16;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b1;
    logic       tx_en = 1'b0;
    logic       port_oe = 1'b0;
    logic       port_dat = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tdr_empty;
    logic       txd;
    logic       txd_oe;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_tx_brk u_uart_tx_brk (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .tx_en     (tx_en),
        .port_oe   (port_oe),
        .port_dat  (port_dat),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .tdr_empty (tdr_empty),
        .txd       (txd),
        .txd_oe    (txd_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
        end
    endtask

    function automatic logic exp_bit(input logic [7:0] b, input logic pen,
                                     input logic podd, input int k);
        if (k == 0) return 1'b0;
        if (k <= 8) return b[k-1];
        if (k == 9 && pen) return (^b) ^ podd;
        return 1'b1;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Called at the negedge where the start bit first shows; follows baud ticks.
    task automatic expect_frame(input logic [7:0] b, input logic pen, input logic podd);
        int nbits = pen ? 11 : 10;
        int t = 0;
        logic pend = 1'b1;
        while (t < OVS * nbits) begin
            logic nxt;
            chk("R3/R4 frame bit", txd, exp_bit(b, pen, podd, t / OVS));
            nxt = baud_tick;
            step();
            if (pend) t++;
            pend = nxt;
        end
    endtask

    // Write a byte into an idle transmitter and check the load latency.
    task automatic write_idle(input logic [7:0] b);
        wr_valid = 1'b1;
        wr_data  = b;
        step();
        wr_valid = 1'b0;
        chk("R6 empty clears on accept", tdr_empty, 1'b0);
        step();
        chk("R7 empty sets on load", tdr_empty, 1'b1);
        chk("R7 line still mark before start", txd, 1'b1);
        step();
    endtask

    task automatic write_now(input logic [7:0] b);
        wr_valid = 1'b1;
        wr_data  = b;
        step();
        wr_valid = 1'b0;
    endtask

    task automatic idle_for(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            chk(req, {txd, txd_oe, tdr_empty}, 3'b111);
            step();
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: a hung run ends as a failure.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                failures++;
                $display("FAIL watchdog expired after %0d cycles", cycles);
                finish_run();
            end
        end
    end

    initial begin
        // R1: reset state.
        @(negedge clk);
        step();
        chk("R1 txd in reset", txd, 1'b1);
        chk("R1 txd_oe in reset", txd_oe, 1'b0);
        chk("R1 empty in reset", tdr_empty, 1'b1);
        rst_n = 1'b1;
        step();
        // R2: port bits own the pin while disabled.
        chk("R2 txd follows port_dat=0", txd, 1'b0);
        chk("R2 oe follows port_oe=0", txd_oe, 1'b0);
        port_oe = 1'b1;
        step();
        chk("R2 oe follows port_oe=1", txd_oe, 1'b1);
        chk("R2 txd still port_dat=0", txd, 1'b0);
        port_dat = 1'b1;
        step();
        chk("R2 txd follows port_dat=1", txd, 1'b1);

        // R6: writes while disabled are ignored.
        write_now(8'h5A);
        chk("R6 write ignored while disabled", tdr_empty, 1'b1);

        // R10 then R5: enabling gives a mark and stays idle.
        port_dat = 1'b0;
        step();
        chk("R2 txd low before enable", txd, 1'b0);
        tx_en = 1'b1;
        step();
        chk("R10 mark after enable", {txd, txd_oe}, 2'b11);
        idle_for(200, "R5 idle mark, no ignored byte sent");

        // R3/R4/R7: every byte value, cycling through parity modes.
        for (int v = 0; v < 256; v++) begin
            par_en  = (v % 3) != 0;
            par_odd = (v % 3) == 2;
            write_idle(v[7:0]);
            expect_frame(v[7:0], par_en, par_odd);
            chk("R5 mark after frame", {txd, txd_oe, tdr_empty}, 3'b111);
        end

        // R8 and R6: back-to-back frames, a write while full is dropped.
        par_en = 1'b1; par_odd = 1'b0;
        write_idle(8'hC3);
        fork
            expect_frame(8'hC3, 1'b1, 1'b0);
            begin
                step();
                write_now(8'h3C);
                chk("R6 queued byte held", tdr_empty, 1'b0);
                write_now(8'hFF);
            end
        join
        expect_frame(8'h3C, 1'b1, 1'b0);
        idle_for(250, "R6 dropped write never sent");

        // R4: baud ticks paused mid-frame hold the line.
        par_en = 1'b0;
        write_idle(8'hA6);
        fork
            expect_frame(8'hA6, 1'b0, 1'b0);
            begin
                logic held;
                for (int i = 0; i < 40; i++) @(negedge clk);
                @(posedge clk); #1 baud_tick = 1'b0;
                @(negedge clk); held = txd;
                for (int i = 0; i < 60; i++) begin
                    @(negedge clk);
                    chk("R4 line stable without ticks", txd, held);
                end
                @(posedge clk); #1 baud_tick = 1'b1;
            end
        join

        // R9: abort mid-frame with a queued byte, hold a break.
        par_en = 1'b1; par_odd = 1'b1;
        write_idle(8'h81);
        write_now(8'h7E);
        for (int i = 0; i < 50; i++) step();
        port_dat = 1'b0;
        port_oe  = 1'b1;
        tx_en    = 1'b0;
        step();
        chk("R9 break level", txd, 1'b0);
        chk("R9 port oe", txd_oe, 1'b1);
        chk("R9 empty after abort", tdr_empty, 1'b1);
        for (int i = 0; i < 40; i++) begin
            chk("R9 break held", txd, 1'b0);
            step();
        end
        port_oe = 1'b0;
        step();
        chk("R2 oe released", txd_oe, 1'b0);
        port_dat = 1'b1;
        step();
        chk("R2 level follows", txd, 1'b1);
        port_dat = 1'b0;
        step();
        chk("R2 low before re-enable", {txd, txd_oe}, 2'b00);
        tx_en = 1'b1;
        step();
        chk("R10 mark after re-enable", {txd, txd_oe}, 2'b11);
        idle_for(300, "R9 discarded bytes not resumed");

        // Normal traffic works after the abort.
        par_en = 1'b0;
        write_idle(8'h42);
        expect_frame(8'h42, 1'b0, 1'b0);
        chk("R5 mark after final frame", {txd, txd_oe, tdr_empty}, 3'b111);

        finish_run();
    end

endmodule